// File: doc/BRIEF.md
# Serial Multi-Bank Register Loader

This block is a write-only three-wire serial slave. It fills three correction memories and a small bank of timing registers. A host lowers the chip select and shifts bytes in, most significant bit first, on the rising edges of the serial clock. The first byte is a bank mask. The second byte is the start address. Every byte after that is data, written to an address that rises by one per byte.

Because the mask is a bitmask, one stream can load the same data into several correction memories and the timing bank at once. The serial pins are synchronised to the internal clock. The memories are fed through a shared address/data bus with one write strobe per memory. The timing registers live inside the block and come out as one flat vector. A busy flag marks the time the chip select is low, so that downstream output stages can hold a fixed level while loading is in progress.

Top module: `serial_bank_loader`

## Requirements
- R1: `busy_o` is 1 while the synchronised chip select is low and 0 otherwise. It follows `cs_ni` with a lag of two clocks. No memory strobe is issued in the cycle after `busy_o` is 0.
- R2: Bits are taken on the rising edge of `sclk_i`, most significant bit first, in groups of eight. Byte one of a transfer is the mask, byte two is the start address, and every later byte is data.
- R3: Mask bit 0, 1 and 2 enable correction memory 0, 1 and 2. Mask bit 3 enables the timing bank. Mask bits 7..4 have no effect. Any combination may be set, so the same data byte reaches every enabled target.
- R4: The first data byte goes to the start address. Each further data byte goes to the previous address plus one.
- R5: A correction memory receives only bits 5..0 of a data byte on `mem_wdata_o`. Bits 7 and 6 are dropped.
- R6: A memory address is {row[3:0], column[3:0]}, with 16 columns and 13 rows. Data bytes aimed at addresses 208 (0xD0) and above give no memory strobe.
- R7: The timing bank has 10 eight-bit registers at addresses 0..9. Register k appears on `tim_regs_o[8k+7:8k]`. Writes to addresses 10 and above leave every register unchanged.
- R8: While `rst_ni` is low, register 0 is 0x0F, register 1 is 0x0D and all other timing registers are 0x00.
- R9: A rise of `cs_ni` discards any partial byte and clears the mask. The next transfer starts again with a mask byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous clear, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdat_i | input | 1 | Serial data |
| mem_we_o | output | 3 | Write strobe, one per correction memory |
| mem_addr_o | output | 8 | Shared memory write address {row, column} |
| mem_wdata_o | output | 6 | Shared memory write data |
| tim_regs_o | output | 80 | Timing registers, register k in bits 8k+7..8k |
| busy_o | output | 1 | Transfer in progress |

## Verification
On every cycle, the assertions check three things. No memory strobe appears after the transfer has ended. No strobe ever targets an address past the last row. An out-of-range timing write leaves the bank untouched. They also check that the framing restarts whenever the chip select is high. Only the bench scenarios can show that a stream lands at the right locations in every bank its mask selects, with the top data bits dropped and the address stepping by one. They also show that a chip select raised mid-byte discards that byte without corrupting the next transfer.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  typedef enum logic [1:0] {PH_MAIN, PH_SUB, PH_DATA} phase_e;
endpackage

// File: rtl/sbl_sync.sv
module sbl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdat_i,
  output logic act_o,
  output logic rise_o,
  output logic bit_o
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] cs_q, ck_q, dt_q;
  logic         ck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= '1;
      ck_q <= '0;
      dt_q <= '0;
      ck_d <= 1'b0;
    end else begin
      cs_q <= {cs_q[MSB-1:0], cs_ni};
      ck_q <= {ck_q[MSB-1:0], sclk_i};
      dt_q <= {dt_q[MSB-1:0], sdat_i};
      ck_d <= ck_q[MSB];
    end
  end

  assign act_o  = ~cs_q[MSB];
  assign rise_o = ck_q[MSB] & ~ck_d;
  assign bit_o  = dt_q[MSB];
endmodule

// File: rtl/sbl_framer.sv
module sbl_framer
  import sbl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       act_i,
  input  logic       rise_i,
  input  logic       bit_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output phase_e     phase_o
);
  logic [2:0] cnt_q;
  logic [6:0] sh_q;
  phase_e     ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sh_q       <= '0;
      ph_q       <= PH_MAIN;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      phase_o    <= PH_MAIN;
    end else begin
      byte_vld_o <= 1'b0;
      if (!act_i) begin
        cnt_q <= '0;
        ph_q  <= PH_MAIN;
      end else if (rise_i) begin
        sh_q  <= {sh_q[5:0], bit_i};
        cnt_q <= cnt_q + 3'd1;
        if (cnt_q == 3'd7) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {sh_q, bit_i};
          phase_o    <= ph_q;
          if (ph_q == PH_MAIN)     ph_q <= PH_SUB;
          else if (ph_q == PH_SUB) ph_q <= PH_DATA;
        end
      end
    end
  end

  // R2
  byte_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(rise_i));

  // R9
  frame_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> (cnt_q == 3'd0) && (ph_q == PH_MAIN));
endmodule

// File: rtl/sbl_steer.sv
module sbl_steer
  import sbl_pkg::*;
#(
  parameter int NB    = 3,
  parameter int DEPTH = 208,
  parameter int AW    = 8,
  parameter int DW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  phase_e        phase_i,
  output logic [NB-1:0] mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [7:0]    reg_wdata_o
);
  localparam logic [AW-1:0] LAST_L = AW'(DEPTH);

  logic [NB:0]   mask_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q      <= '0;
      addr_q      <= '0;
      mem_we_o    <= '0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      reg_we_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
    end else begin
      mem_we_o <= '0;
      reg_we_o <= 1'b0;
      if (!act_i) begin
        mask_q <= '0;
      end else if (byte_vld_i) begin
        case (phase_i)
          PH_MAIN: mask_q <= byte_i[NB:0];
          PH_SUB:  addr_q <= byte_i[AW-1:0];
          default: begin
            for (int b = 0; b < NB; b++)
              mem_we_o[b] <= mask_q[b] && (addr_q < LAST_L);
            reg_we_o    <= mask_q[NB];
            mem_addr_o  <= addr_q;
            reg_addr_o  <= addr_q;
            mem_wdata_o <= byte_i[DW-1:0];
            reg_wdata_o <= byte_i;
            addr_q      <= addr_q + 1'b1;
          end
        endcase
      end
    end
  end

  // R1
  no_late_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> mem_we_o == '0);

  // R6
  addr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o != '0) |-> (mem_addr_o < LAST_L));
endmodule

// File: rtl/sbl_regs.sv
module sbl_regs #(
  parameter int                  NREG = 10,
  parameter int                  AW   = 8,
  parameter logic [NREG*8-1:0]   RST  = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [7:0]        wdata_i,
  output logic [NREG*8-1:0] regs_o
);
  localparam logic [AW-1:0] NREG_L = AW'(NREG);

  logic [NREG*8-1:0] regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= RST;
    end else if (we_i) begin
      for (int k = 0; k < NREG; k++)
        if (addr_i == AW'(k)) regs_q[k*8 +: 8] <= wdata_i;
    end
  end

  assign regs_o = regs_q;

  // R7
  reg_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i >= NREG_L)) |=> $stable(regs_q));
endmodule

// File: rtl/serial_bank_loader.sv
module serial_bank_loader
  import sbl_pkg::*;
#(
  parameter int                    NUM_BANKS = 3,
  parameter int                    COLS      = 16,
  parameter int                    ROWS      = 13,
  parameter int                    AW        = 8,
  parameter int                    DW        = 6,
  parameter int                    NUM_REGS  = 10,
  parameter int                    SYNC      = 2,
  parameter logic [NUM_REGS*8-1:0] REG_RST   = 80'h0000_0000_0000_0000_0D0F
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  sclk_i,
  input  logic                  sdat_i,
  output logic [NUM_BANKS-1:0]  mem_we_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic [DW-1:0]         mem_wdata_o,
  output logic [NUM_REGS*8-1:0] tim_regs_o,
  output logic                  busy_o
);
  localparam int DEPTH = COLS * ROWS;

  logic          act, rise, sbit, bvld, reg_we;
  logic [7:0]    bval, reg_wdata;
  logic [AW-1:0] reg_addr;
  phase_e        phase;

  sbl_sync #(.STAGES(SYNC)) i_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .sdat_i,
    .act_o(act), .rise_o(rise), .bit_o(sbit)
  );

  sbl_framer i_framer (
    .clk_i, .rst_ni, .act_i(act), .rise_i(rise), .bit_i(sbit),
    .byte_vld_o(bvld), .byte_o(bval), .phase_o(phase)
  );

  sbl_steer #(.NB(NUM_BANKS), .DEPTH(DEPTH), .AW(AW), .DW(DW)) i_steer (
    .clk_i, .rst_ni, .act_i(act), .byte_vld_i(bvld), .byte_i(bval),
    .phase_i(phase), .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .reg_we_o(reg_we), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata)
  );

  sbl_regs #(.NREG(NUM_REGS), .AW(AW), .RST(REG_RST)) i_regs (
    .clk_i, .rst_ni, .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .regs_o(tim_regs_o)
  );

  assign busy_o = act;
endmodule

// File: tb/test_serial_bank_loader.sv
module test_serial_bank_loader;
  localparam logic [79:0] DEF_REGS = 80'h0000_0000_0000_0000_0D0F;
  // {mask, start, data0, data1}
  localparam logic [31:0] VEC [9] = '{
    32'h01_00_3F_15, 32'h02_CE_2A_C7, 32'h04_55_81_7E,
    32'h0F_05_A5_5A, 32'h08_08_11_22, 32'h07_CF_33_44,
    32'h08_09_99_77, 32'hF1_10_0C_0D, 32'h00_20_01_02
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdat = 1'b0;
  logic [2:0]  mem_we;
  logic [7:0]  mem_addr;
  logic [5:0]  mem_wdata;
  logic [79:0] tim_regs;
  logic        busy;

  logic [5:0]  cap_mem [3][256];
  logic [5:0]  exp_mem [3][256];
  int          cap_cnt [3];
  int          exp_cnt [3];
  logic [79:0] exp_regs;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  serial_bank_loader i_serial_bank_loader (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdat_i(sdat),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .tim_regs_o(tim_regs), .busy_o(busy)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 3; b++) begin
        cap_cnt[b] = 0;
        for (int a = 0; a < 256; a++) cap_mem[b][a] = '0;
      end
    end else begin
      for (int b = 0; b < 3; b++)
        if (mem_we[b]) begin
          cap_mem[b][mem_addr] = mem_wdata;
          cap_cnt[b] = cap_cnt[b] + 1;
        end
    end
  end

  task automatic check(bit ok, string req, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] v, int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sclk = 1'b0; sdat = v[i]; wait_clk(6);
      sclk = 1'b1; wait_clk(6);
    end
    sclk = 1'b0;
  endtask

  task automatic model(logic [7:0] mask, logic [7:0] a, logic [7:0] d);
    for (int b = 0; b < 3; b++)
      if (mask[b] && a < 8'd208) begin
        exp_mem[b][a] = d[5:0];
        exp_cnt[b]++;
      end
    if (mask[3] && a < 8'd10) exp_regs[a*8 +: 8] = d;
  endtask

  task automatic compare(string req);
    for (int b = 0; b < 3; b++) begin
      int diff = 0;
      int first = 0;
      for (int a = 0; a < 256; a++)
        if (cap_mem[b][a] !== exp_mem[b][a]) begin
          if (diff == 0) first = a;
          diff++;
        end
      check(diff == 0, req, 80'(cap_mem[b][first]), 80'(exp_mem[b][first]));
      check(cap_cnt[b] == exp_cnt[b], req, 80'(cap_cnt[b]), 80'(exp_cnt[b]));
    end
    check(tim_regs === exp_regs, req, tim_regs, exp_regs);
  endtask

  task automatic transfer(logic [31:0] v);
    cs_n = 1'b0; wait_clk(8);
    for (int k = 3; k >= 0; k--) send_bits(v[k*8 +: 8], 8);
    wait_clk(6);
    cs_n = 1'b1; wait_clk(8);
    model(v[31:24], v[23:16], v[15:8]);
    model(v[31:24], v[23:16] + 8'd1, v[7:0]);
  endtask

  initial begin
    for (int b = 0; b < 3; b++) begin
      exp_cnt[b] = 0;
      for (int a = 0; a < 256; a++) exp_mem[b][a] = '0;
    end
    exp_regs = DEF_REGS;
    wait_clk(4);
    // R8 defaults held in reset
    check(tim_regs === DEF_REGS, "R8", tim_regs, DEF_REGS);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 idle state
    check(busy === 1'b0, "R1", 80'(busy), 80'h0);
    check(mem_we === 3'b000, "R1", 80'(mem_we), 80'h0);

    // R2 R3 R4 R5 R6 R7: table walk
    for (int i = 0; i < 9; i++) begin
      transfer(VEC[i]);
      compare("R2/R3/R4/R5/R6/R7");
    end

    // R1 busy follows chip select
    cs_n = 1'b0; wait_clk(4);
    check(busy === 1'b1, "R1", 80'(busy), 80'h1);
    cs_n = 1'b1; wait_clk(4);
    check(busy === 1'b0, "R1", 80'(busy), 80'h0);

    // R9 abort mid-byte, then fresh transfer
    cs_n = 1'b0; wait_clk(8);
    send_bits(8'h01, 8);
    send_bits(8'h30, 8);
    send_bits(8'hFF, 4);
    wait_clk(6);
    cs_n = 1'b1; wait_clk(8);
    compare("R9");
    transfer(32'h02_31_05_06);
    compare("R9");

    // R8 clear restores defaults
    rst_n = 1'b0; wait_clk(2);
    check(tim_regs === DEF_REGS, "R8", tim_regs, DEF_REGS);
    rst_n = 1'b1; wait_clk(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule